// File: doc/BRIEF.md
# Double-Buffered Display Configuration Register Bank

This block holds the configuration words that steer a four-layer display compositor. Every word exists twice. Software reads and writes a staging copy over a simple word-addressed bus. A second, active copy drives the pixel pipeline. The active copies change only inside a vertical blanking cycle, and all of them change together, so a frame never sees a half-written setup.

A transfer from staging to active happens in two cases. In the first, software sets a self-clearing load request bit and the next blank performs the copy. In the second, automatic reloading is enabled and every blank performs the copy. A separate bit turns automatic reloading off. The load request bit reads back as 1 until the blank that services it, so software can poll it before staging the next frame.

The bus has no back-pressure. A write completes in the cycle it is presented. A read returns its data one cycle later, flagged by `rd_valid`. The `vblank` input is a one-cycle pulse per blanking interval.

Top module: `disp_regbank`

## Requirements
- R1: After reset, every staging and active word is zero, the load request is clear and automatic reloading is enabled (control word reads 0).
- R2: A read returns the staging copy one cycle after `rd_en`, with `rd_valid` high in that cycle. Byte addresses that map no register read as 0, and writes to them have no effect.
- R3: Active outputs change only in a cycle where `commit_pulse` is high, and `commit_pulse` is high only while `vblank` is high.
- R4: Writing the control word at 0x004 with bit 0 set raises the load request. The request reads back as bit 0 and shows on `load_pending` until the next `vblank`, which copies staging to active and clears it.
- R5: Bit 1 of the control word disables automatic reloading. While it is 0, every `vblank` commits. While it is 1, a `vblank` without a pending request commits nothing.
- R6: A pending load request is cleared by the next `vblank` even when automatic reloading is enabled.
- R7: When a staging write and `vblank` share a cycle, the commit copies the value held before the write. The new value stays staged: it reads back but is not active until the next commit.
- R8: The mode word at 0x000 maps bit 0 to module enable, bit 1 to start, bit 2 to interlace, and bit 8+i to the enable of layer i.
- R9: Layer i's framebuffer bit address is 36 bits. The low 32 bits come from 0x850+4i, and bits 35:32 come from bits 4i+3:4i of the shared word at 0x860.
- R10: Layer i's size word sits at 0x800+4i, its position word at 0x810+4i and its line pitch at 0x840+4i. Each appears unchanged on its active output.
- R11: A load request written in the same cycle as a `vblank` is not consumed by that blank. It stays pending for the following one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write byte address (bits 1:0 ignored) |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read byte address |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| rd_data | output | 32 | Read data |
| vblank | input | 1 | One-cycle vertical blanking pulse |
| commit_pulse | output | 1 | High in the cycle that copies staging to active |
| load_pending | output | 1 | Load request outstanding |
| act_module_en | output | 1 | Active module enable |
| act_start | output | 1 | Active start control |
| act_interlace | output | 1 | Active interlace enable |
| act_layer_en | output | NLAYER | Active per-layer enables |
| act_layer_size | output | NLAYER x 32 | Active layer size words |
| act_layer_pos | output | NLAYER x 32 | Active layer position words |
| act_layer_pitch | output | NLAYER x 32 | Active layer line pitch in bits |
| act_layer_fbaddr | output | NLAYER x 36 | Active layer framebuffer bit address |

## Verification
The hardest case to reach is a write that lands in the same cycle as the blank. A staging write or a new load request then competes with the transfer that reads the old state. The bench has a dedicated task that raises `vblank` together with a bus write. It uses this task for a data word, with a commit already pending, and for the control word, with automatic reloading off and nothing pending. In both cases it checks that the blank commits the prior state and that the new value, or the new request, survives into the next interval.

// File: rtl/dbr_pkg.sv
package dbr_pkg;
  localparam int unsigned WORD_W  = 32;
  localparam int unsigned HI_W    = 4;
  localparam int unsigned NFIELD  = 4;   // per-layer word kinds

  // byte offsets of the map
  localparam int unsigned OFS_MODE  = 'h000;
  localparam int unsigned OFS_CTL   = 'h004;
  localparam int unsigned OFS_SIZE  = 'h800;
  localparam int unsigned OFS_POS   = 'h810;
  localparam int unsigned OFS_PITCH = 'h840;
  localparam int unsigned OFS_ADRLO = 'h850;
  localparam int unsigned OFS_ADRHI = 'h860;

  // bit positions
  localparam int unsigned MB_ENABLE = 0;
  localparam int unsigned MB_START  = 1;
  localparam int unsigned MB_ILACE  = 2;
  localparam int unsigned MB_LAYER0 = 8;
  localparam int unsigned CB_LOAD   = 0;
  localparam int unsigned CB_NOAUTO = 1;

  typedef enum logic [1:0] {
    LF_SIZE  = 2'd0,
    LF_POS   = 2'd1,
    LF_PITCH = 2'd2,
    LF_ADRLO = 2'd3
  } layer_field_e;

  // word index layout inside the banks: 0 mode, 1 shared high address,
  // then NFIELD groups of NLAYER words
  localparam int unsigned IX_MODE  = 0;
  localparam int unsigned IX_ADRHI = 1;
  localparam int unsigned IX_LAYER = 2;

  function automatic int unsigned field_base(input int unsigned f);
    case (f)
      0:       return OFS_SIZE;
      1:       return OFS_POS;
      2:       return OFS_PITCH;
      default: return OFS_ADRLO;
    endcase
  endfunction

  function automatic int unsigned layer_index(input int unsigned f,
                                              input int unsigned l,
                                              input int unsigned nl);
    return IX_LAYER + f * nl + l;
  endfunction
endpackage

// File: rtl/dbr_decode.sv
module dbr_decode
  import dbr_pkg::*;
#(
  parameter int unsigned NLAYER = 4,
  parameter int unsigned ADDR_W = 15,
  parameter int unsigned NREG   = 2 + NFIELD * NLAYER,
  parameter int unsigned IDX_W  = $clog2(NREG)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [IDX_W-1:0]  idx,
  output logic              is_ctl
);
  always_comb begin
    hit    = 1'b0;
    idx    = '0;
    is_ctl = (addr == ADDR_W'(OFS_CTL));
    if (addr == ADDR_W'(OFS_MODE)) begin
      hit = 1'b1;
      idx = IDX_W'(IX_MODE);
    end
    if (addr == ADDR_W'(OFS_ADRHI)) begin
      hit = 1'b1;
      idx = IDX_W'(IX_ADRHI);
    end
    for (int f = 0; f < int'(NFIELD); f++) begin
      for (int l = 0; l < int'(NLAYER); l++) begin
        if (addr == ADDR_W'(field_base(f) + 4 * l)) begin
          hit = 1'b1;
          idx = IDX_W'(layer_index(f, l, NLAYER));
        end
      end
    end
  end
endmodule

// File: rtl/dbr_stage_bank.sv
module dbr_stage_bank
  import dbr_pkg::*;
#(
  parameter int unsigned NREG  = 18,
  parameter int unsigned IDX_W = $clog2(NREG)
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         we,
  input  logic [IDX_W-1:0]             widx,
  input  logic [WORD_W-1:0]            wdata,
  output logic [NREG-1:0][WORD_W-1:0]  q
);
  for (genvar g = 0; g < int'(NREG); g++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)
        q[g] <= '0;
      else if (we && (widx == IDX_W'(g)))
        q[g] <= wdata;
    end
  end
endmodule

// File: rtl/dbr_active_bank.sv
module dbr_active_bank
  import dbr_pkg::*;
#(
  parameter int unsigned NREG = 18
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         load,
  input  logic [NREG-1:0][WORD_W-1:0]  d,
  output logic [NREG-1:0][WORD_W-1:0]  q
);
  for (genvar g = 0; g < int'(NREG); g++) begin : g_word
    always_ff @(posedge clk) begin
      if (!rst_n)
        q[g] <= '0;
      else if (load)
        q[g] <= d[g];
    end
  end
endmodule

// File: rtl/dbr_commit_ctl.sv
module dbr_commit_ctl
  import dbr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctl_we,
  input  logic [1:0] ctl_wdata,
  input  logic       vblank,
  output logic       pend,
  output logic       auto_off,
  output logic       xfer
);
  // transfer decided from the registered state only, so a same-cycle
  // write cannot influence the blank it coincides with
  assign xfer = vblank & (pend | ~auto_off);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend     <= 1'b0;
      auto_off <= 1'b0;
    end else begin
      if (ctl_we)
        auto_off <= ctl_wdata[CB_NOAUTO];
      if (ctl_we && ctl_wdata[CB_LOAD])
        pend <= 1'b1;
      else if (vblank)
        pend <= 1'b0;
    end
  end
endmodule

// File: rtl/disp_regbank.sv
module disp_regbank
  import dbr_pkg::*;
#(
  parameter int unsigned NLAYER = 4,   // at most 4: layer words are 0x10 apart
  parameter int unsigned ADDR_W = 15
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [ADDR_W-1:0]              wr_addr,
  input  logic [31:0]                    wr_data,
  input  logic                           rd_en,
  input  logic [ADDR_W-1:0]              rd_addr,
  output logic                           rd_valid,
  output logic [31:0]                    rd_data,
  input  logic                           vblank,
  output logic                           commit_pulse,
  output logic                           load_pending,
  output logic                           act_module_en,
  output logic                           act_start,
  output logic                           act_interlace,
  output logic [NLAYER-1:0]              act_layer_en,
  output logic [NLAYER-1:0][31:0]        act_layer_size,
  output logic [NLAYER-1:0][31:0]        act_layer_pos,
  output logic [NLAYER-1:0][31:0]        act_layer_pitch,
  output logic [NLAYER-1:0][35:0]        act_layer_fbaddr
);
  localparam int unsigned NREG  = IX_LAYER + NFIELD * NLAYER;
  localparam int unsigned IDX_W = $clog2(NREG);

  logic               w_hit, w_ctl, r_hit, r_ctl;
  logic [IDX_W-1:0]   w_idx, r_idx;
  logic               auto_off;
  logic [NREG-1:0][WORD_W-1:0] stage_q, act_q;

  dbr_decode #(.NLAYER(NLAYER), .ADDR_W(ADDR_W), .NREG(NREG), .IDX_W(IDX_W))
    u_wdec (.addr({wr_addr[ADDR_W-1:2], 2'b00}), .hit(w_hit), .idx(w_idx), .is_ctl(w_ctl));

  dbr_decode #(.NLAYER(NLAYER), .ADDR_W(ADDR_W), .NREG(NREG), .IDX_W(IDX_W))
    u_rdec (.addr({rd_addr[ADDR_W-1:2], 2'b00}), .hit(r_hit), .idx(r_idx), .is_ctl(r_ctl));

  dbr_commit_ctl u_ctl (
    .clk(clk), .rst_n(rst_n),
    .ctl_we(wr_en & w_ctl), .ctl_wdata(wr_data[1:0]),
    .vblank(vblank),
    .pend(load_pending), .auto_off(auto_off), .xfer(commit_pulse)
  );

  dbr_stage_bank #(.NREG(NREG), .IDX_W(IDX_W)) u_stage (
    .clk(clk), .rst_n(rst_n),
    .we(wr_en & w_hit), .widx(w_idx), .wdata(wr_data),
    .q(stage_q)
  );

  dbr_active_bank #(.NREG(NREG)) u_active (
    .clk(clk), .rst_n(rst_n),
    .load(commit_pulse), .d(stage_q), .q(act_q)
  );

  // registered read port
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        if (r_ctl)
          rd_data <= {30'd0, auto_off, load_pending};
        else if (r_hit)
          rd_data <= stage_q[r_idx];
        else
          rd_data <= '0;
      end
    end
  end

  // active field fan-out
  assign act_module_en = act_q[IX_MODE][MB_ENABLE];
  assign act_start     = act_q[IX_MODE][MB_START];
  assign act_interlace = act_q[IX_MODE][MB_ILACE];

  for (genvar l = 0; l < int'(NLAYER); l++) begin : g_layer
    localparam int unsigned IS = layer_index(LF_SIZE,  l, NLAYER);
    localparam int unsigned IP = layer_index(LF_POS,   l, NLAYER);
    localparam int unsigned IW = layer_index(LF_PITCH, l, NLAYER);
    localparam int unsigned IA = layer_index(LF_ADRLO, l, NLAYER);
    assign act_layer_en[l]     = act_q[IX_MODE][MB_LAYER0 + l];
    assign act_layer_size[l]   = act_q[IS];
    assign act_layer_pos[l]    = act_q[IP];
    assign act_layer_pitch[l]  = act_q[IW];
    assign act_layer_fbaddr[l] = {act_q[IX_ADRHI][HI_W*l +: HI_W], act_q[IA]};
  end
endmodule

// File: rtl/dbr_regbank_checker.sv
module dbr_regbank_checker #(
  parameter int unsigned NLAYER = 4,
  parameter int unsigned ADDR_W = 15
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    wr_en,
  input logic [ADDR_W-1:0]       wr_addr,
  input logic [31:0]             wr_data,
  input logic                    rd_en,
  input logic                    rd_valid,
  input logic                    vblank,
  input logic                    commit_pulse,
  input logic                    load_pending,
  input logic                    auto_off,
  input logic [NLAYER-1:0]       act_layer_en,
  input logic [NLAYER-1:0][31:0] act_layer_size,
  input logic [NLAYER-1:0][35:0] act_layer_fbaddr
);
  logic req_wr;
  assign req_wr = wr_en && (wr_addr[ADDR_W-1:2] == (ADDR_W-2)'(1)) && wr_data[0];

  p_rd_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  p_rd_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);
  p_commit_in_blank_r3: assert property (@(posedge clk) disable iff (!rst_n)
    commit_pulse |-> vblank);
  p_active_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_pulse |=> ($stable(act_layer_size) && $stable(act_layer_fbaddr)
                       && $stable(act_layer_en)));
  p_pend_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    req_wr |=> load_pending);
  p_pend_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (load_pending && !vblank) |=> load_pending);
  p_autoload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (vblank && !auto_off) |-> commit_pulse);
  p_no_auto_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (vblank && auto_off && !load_pending) |-> !commit_pulse);
  p_pend_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (vblank && !req_wr) |=> !load_pending);
  p_pend_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (vblank && load_pending) |-> commit_pulse);
endmodule

bind disp_regbank dbr_regbank_checker #(.NLAYER(NLAYER), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .rd_en(rd_en), .rd_valid(rd_valid), .vblank(vblank),
  .commit_pulse(commit_pulse), .load_pending(load_pending), .auto_off(auto_off),
  .act_layer_en(act_layer_en), .act_layer_size(act_layer_size),
  .act_layer_fbaddr(act_layer_fbaddr)
);

// File: tb/disp_regbank_bench.sv
`timescale 1ns/1ps
module disp_regbank_bench;
  localparam int NL = 4;
  localparam int AW = 15;
  localparam int WD_CYCLES = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0, vblank = 1'b0;
  logic [AW-1:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic rd_valid, commit_pulse, load_pending;
  logic [31:0] rd_data;
  logic act_module_en, act_start, act_interlace;
  logic [NL-1:0] act_layer_en;
  logic [NL-1:0][31:0] act_layer_size, act_layer_pos, act_layer_pitch;
  logic [NL-1:0][35:0] act_layer_fbaddr;

  always #2.5 clk = ~clk;

  disp_regbank #(.NLAYER(NL), .ADDR_W(AW)) u_disp_regbank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rd_valid), .rd_data(rd_data),
    .vblank(vblank), .commit_pulse(commit_pulse), .load_pending(load_pending),
    .act_module_en(act_module_en), .act_start(act_start), .act_interlace(act_interlace),
    .act_layer_en(act_layer_en), .act_layer_size(act_layer_size),
    .act_layer_pos(act_layer_pos), .act_layer_pitch(act_layer_pitch),
    .act_layer_fbaddr(act_layer_fbaddr)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL R2: unexpected read data %0h expected none", rd_data);
      end else begin
        check(tag_q.pop_front(), 64'(rd_data), 64'(exp_q.pop_front()));
      end
    end
  end

  task automatic wr(input int a, input logic [31:0] d);
    wr_en = 1; wr_addr = AW'(a); wr_data = d;
    @(posedge clk); #1;
    wr_en = 0;
  endtask

  task automatic rd(input int a, input logic [31:0] e, input string tag);
    rd_en = 1; rd_addr = AW'(a);
    exp_q.push_back(e); tag_q.push_back(tag);
    @(posedge clk); #1;
    rd_en = 0;
  endtask

  task automatic vb(input logic exp_commit, input string tag);
    vblank = 1; #1;
    check(tag, 64'(commit_pulse), 64'(exp_commit));
    @(posedge clk); #1;
    vblank = 0;
  endtask

  task automatic wr_vb(input int a, input logic [31:0] d, input logic exp_commit, input string tag);
    wr_en = 1; wr_addr = AW'(a); wr_data = d; vblank = 1; #1;
    check(tag, 64'(commit_pulse), 64'(exp_commit));
    @(posedge clk); #1;
    wr_en = 0; vblank = 0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run hung, got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    check("R1 pending", 64'(load_pending), 0);
    check("R1 size", 64'(act_layer_size), 0);
    check("R1 fbaddr", 64'(act_layer_fbaddr[3]), 0);
    check("R1 mode", 64'({act_module_en, act_start, act_interlace, act_layer_en}), 0);
    rd('h004, 0, "R1 ctl");
    rd('h800, 0, "R1 staged size");

    // R2/R3/R5 autoload on by default
    wr('h800, 32'h0040_0030);
    rd('h800, 32'h0040_0030, "R2 readback");
    check("R3 not yet active", 64'(act_layer_size[0]), 0);
    vb(1, "R5 autoload commit");
    check("R5 size active", 64'(act_layer_size[0]), 64'h0040_0030);

    // R5 autoload off: blank without request does nothing
    wr('h004, 2);
    rd('h004, 2, "R5 ctl readback");
    wr('h814, 32'h10);
    vb(0, "R5 no commit");
    check("R5 pos held", 64'(act_layer_pos[1]), 0);

    // R4 load request
    wr('h004, 3);
    check("R4 pending", 64'(load_pending), 1);
    rd('h004, 3, "R4 ctl pending");
    repeat (3) @(posedge clk); #1;
    check("R4 still pending", 64'(load_pending), 1);
    check("R3 waits blank", 64'(act_layer_pos[1]), 0);
    vb(1, "R4 commit");
    check("R10 pos active", 64'(act_layer_pos[1]), 64'h10);
    check("R4 cleared", 64'(load_pending), 0);
    rd('h004, 2, "R4 ctl cleared");

    // R8 mode fields
    wr('h000, 32'h0000_0507);
    wr('h004, 3);
    vb(1, "R8 commit");
    check("R8 flags", 64'({act_module_en, act_start, act_interlace}), 64'b111);
    check("R8 layer enables", 64'(act_layer_en), 64'b0101);

    // R9/R10 addresses and pitch
    wr('h858, 32'hDEAD_BEE0);
    wr('h860, 32'h0000_0A00);
    wr('h84C, 32'h0000_1E00);
    wr('h004, 3);
    vb(1, "R9 commit");
    check("R9 layer2 addr", 64'(act_layer_fbaddr[2]), 64'hA_DEAD_BEE0);
    check("R9 layer0 addr", 64'(act_layer_fbaddr[0]), 0);
    check("R10 pitch", 64'(act_layer_pitch[3]), 64'h1E00);

    // R7 write coinciding with blank
    wr('h800, 32'h111);
    wr('h004, 3);
    wr_vb('h800, 32'h222, 1, "R7 commit");
    check("R7 old value active", 64'(act_layer_size[0]), 64'h111);
    check("R7 request used", 64'(load_pending), 0);
    rd('h800, 32'h222, "R7 new staged");
    wr('h004, 3);
    vb(1, "R7 second commit");
    check("R7 new value active", 64'(act_layer_size[0]), 64'h222);

    // R6 request cleared with autoload on
    wr('h004, 1);
    check("R6 pending", 64'(load_pending), 1);
    vb(1, "R6 commit");
    check("R6 cleared", 64'(load_pending), 0);

    // R11 request written during blank survives it
    wr('h004, 2);
    wr('h810, 32'h55);
    wr_vb('h004, 3, 0, "R11 no commit");
    check("R11 still pending", 64'(load_pending), 1);
    check("R11 pos held", 64'(act_layer_pos[0]), 0);
    vb(1, "R11 commit");
    check("R11 pos active", 64'(act_layer_pos[0]), 64'h55);

    // R2 unmapped addresses
    wr('h900, 32'hFFFF_FFFF);
    wr('h5800, 32'hFFFF_FFFF);
    rd('h900, 0, "R2 unmapped window");
    rd('h5800, 0, "R2 top address");
    wr('h004, 3);
    vb(1, "R2 commit");
    check("R2 size untouched", 64'(act_layer_size), 64'({32'h0, 32'h0, 32'h0, 32'h222}));

    repeat (3) @(posedge clk);
    check("R2 queue drained", 64'(exp_q.size()), 0);
    finish_run();
  end
endmodule